// File: doc/BRIEF.md
# Host Wake-Up Command Port

This block is the single host-visible I/O port of an intelligent peripheral board. A host I/O write is compared against a configured port address. In 16-bit mode all sixteen address bits must agree. In 8-bit mode only the low address byte is compared and the high byte does not matter. When the address matches, the two low data bits carry a command. The command either holds the board's local processor in reset, releases it, or gives it a one-cycle channel-attention pulse. A command takes effect when the host write strobe ends.

The block also holds the board's interrupt request to the host. The local processor raises it with a local I/O write to a fixed port. The host drops it with the same command that releases reset. While the request is pending, one of eight active-low interrupt priority lines is pulled low. The line is picked by a one-hot configuration input. The other lines stay high, which is the released level of an open-drain line.

Top module: `host_wake_port`

## Requirements
- R1: In 16-bit mode (`cfg_addr16_i`=1), a host write acts only when all 16 bits of `host_addr_i` equal `cfg_port_addr_i`. A write to any other address leaves `board_rst_o`, `chan_attn_o` and `host_irq_no` unchanged.
- R2: In 8-bit mode (`cfg_addr16_i`=0), only bits [7:0] of the address are compared. Bits [15:8] have no effect on whether the write acts.
- R3: Only `host_data_i[1:0]` is decoded, so bits [7:2] have no effect. Code 2'b11 does nothing.
- R4: Code 2'b10 sets `board_rst_o` to 1. It stays 1 through any other write until a code 2'b00 write.
- R5: Code 2'b00 clears `board_rst_o` and clears the pending interrupt at the same clock edge.
- R6: The command acts at the first rising edge where `host_iowr_i` is sampled low after being sampled high. Address and data are taken from the last cycle in which the strobe was high. Code 2'b01 then drives `chan_attn_o` high for exactly the one cycle after that edge. The pulse is suppressed if `board_rst_o` was 1 before that edge.
- R7: A one-cycle local write (`loc_iowr_i`) to address 16'h8010 with `loc_data_i[8]`=1 sets the pending interrupt. Any other local write has no effect. If a set and a host clear fall on the same edge, the interrupt ends up set.
- R8: While the interrupt is pending, `host_irq_no[i]` is 0 for each i where `cfg_irq_sel_i[i]` is 1. Every other line is 1. With no interrupt pending, all lines are 1.
- R9: While `rst_ni` is low, and after it rises, `board_rst_o` is 1, `chan_attn_o` is 0 and no interrupt is pending (all `host_irq_no` lines are 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cfg_port_addr_i | input | 16 | Configured wake-up port address |
| cfg_addr16_i | input | 1 | 1: compare all 16 bits; 0: compare low byte only |
| cfg_irq_sel_i | input | 8 | One-hot choice of the host interrupt line |
| host_iowr_i | input | 1 | Host I/O write strobe, active high, synchronous |
| host_addr_i | input | 16 | Host I/O address |
| host_data_i | input | 8 | Host command byte |
| loc_iowr_i | input | 1 | Local processor I/O write, one cycle |
| loc_addr_i | input | 16 | Local I/O address |
| loc_data_i | input | 16 | Local I/O write data |
| board_rst_o | output | 1 | Reset to the local processor and board control register, active high |
| chan_attn_o | output | 1 | One-cycle channel-attention pulse |
| host_irq_no | output | 8 | Active-low interrupt priority lines, released lines high |

## Verification
The controller keeps very little state: the captured strobe, address match and command, the reset flag, and the interrupt latch. A fault in any of these shows up at the ports within one cycle of the write that ends. A lost capture shows as a missing or misplaced `chan_attn_o` pulse, or as `board_rst_o` not changing, in the cycle after the trailing edge. A bad latch shows at once on `host_irq_no`, and the bench checks it after every write. The bench sweeps all 256 command bytes, flips each address bit in both compare modes, and walks the interrupt line through all eight choices, so a wrong decode or compare is seen on the first write that reaches it.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    CMD_CLEAR = 2'b00,
    CMD_ATTN  = 2'b01,
    CMD_RESET = 2'b10,
    CMD_NONE  = 2'b11
  } wake_cmd_e;
endpackage

// File: rtl/wake_addr_match.sv
module wake_addr_match #(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              wide_i,
  output logic              hit_o
);
  logic lo_ok;
  logic hi_ok;

  assign lo_ok = (addr_i[LO_W-1:0] == cfg_addr_i[LO_W-1:0]);

  generate
    if (ADDR_W > LO_W) begin : g_hi
      assign hi_ok = !wide_i || (addr_i[ADDR_W-1:LO_W] == cfg_addr_i[ADDR_W-1:LO_W]);
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign hit_o = lo_ok && hi_ok;

  always_comb begin
    if (wide_i && (addr_i != cfg_addr_i))
      assert_wide_miss_R1: assert (!hit_o);
  end
endmodule

// File: rtl/wake_cmd_ctrl.sv
module wake_cmd_ctrl
  import wake_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      strobe_i,
  input  logic      hit_i,
  input  wake_cmd_e cmd_i,
  output logic      board_rst_o,
  output logic      attn_o,
  output logic      clr_irq_o
);
  logic      stb_q;
  logic      hit_q;
  wake_cmd_e cmd_q;
  logic      trail;

  // act once the strobe has ended, using the last captured cycle
  assign trail     = stb_q && !strobe_i && hit_q;
  assign clr_irq_o = trail && (cmd_q == CMD_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q       <= 1'b0;
      hit_q       <= 1'b0;
      cmd_q       <= CMD_NONE;
      board_rst_o <= 1'b1;
      attn_o      <= 1'b0;
    end else begin
      stb_q  <= strobe_i;
      attn_o <= 1'b0;
      if (strobe_i) begin
        hit_q <= hit_i;
        cmd_q <= cmd_i;
      end
      if (trail) begin
        unique case (cmd_q)
          CMD_CLEAR: board_rst_o <= 1'b0;
          CMD_ATTN:  attn_o      <= !board_rst_o;
          CMD_RESET: board_rst_o <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  assert_attn_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |=> !attn_o);
  assert_attn_not_in_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |-> !board_rst_o);
  assert_attn_on_trailing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(attn_o) |-> $past(stb_q && !strobe_i));
  assert_rst_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(board_rst_o) |-> $past(cmd_q == CMD_CLEAR && hit_q));
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int          NUM_IRQ  = 8,
  parameter int          LADDR_W  = 16,
  parameter int          LDATA_W  = 16,
  parameter logic [15:0] IRQ_PORT = 16'h8010,
  parameter int          IRQ_BIT  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               loc_wr_i,
  input  logic [LADDR_W-1:0] loc_addr_i,
  input  logic [LDATA_W-1:0] loc_data_i,
  input  logic               clr_i,
  input  logic [NUM_IRQ-1:0] sel_i,
  output logic [NUM_IRQ-1:0] irq_no,
  output logic               pending_o
);
  localparam logic [LADDR_W-1:0] PORT = LADDR_W'(IRQ_PORT);

  logic set_hit;
  assign set_hit = loc_wr_i && (loc_addr_i == PORT) && loc_data_i[IRQ_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pending_o <= 1'b0;
    else if (set_hit) pending_o <= 1'b1;
    else if (clr_i)   pending_o <= 1'b0;
  end

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      assign irq_no[g] = !(pending_o && sel_i[g]);
    end
  endgenerate

  assert_set_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_o) |-> $past(loc_wr_i && loc_addr_i == PORT));
  assert_clear_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pending_o) |-> $past(clr_i));
  assert_one_line_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i) |-> $onehot0(~irq_no));
  assert_idle_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_o |-> (&irq_no));
endmodule

// File: rtl/host_wake_port.sv
module host_wake_port
  import wake_pkg::*;
#(
  parameter int          HADDR_W  = 16,
  parameter int          HDATA_W  = 8,
  parameter int          LADDR_W  = 16,
  parameter int          LDATA_W  = 16,
  parameter int          NUM_IRQ  = 8,
  parameter logic [15:0] IRQ_PORT = 16'h8010,
  parameter int          IRQ_BIT  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] cfg_port_addr_i,
  input  logic               cfg_addr16_i,
  input  logic [NUM_IRQ-1:0] cfg_irq_sel_i,
  input  logic               host_iowr_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic [HDATA_W-1:0] host_data_i,
  input  logic               loc_iowr_i,
  input  logic [LADDR_W-1:0] loc_addr_i,
  input  logic [LDATA_W-1:0] loc_data_i,
  output logic               board_rst_o,
  output logic               chan_attn_o,
  output logic [NUM_IRQ-1:0] host_irq_no
);
  localparam int LO_W = (HADDR_W < 8) ? HADDR_W : 8;

  logic      hit;
  logic      clr_irq;
  logic      pending;
  wake_cmd_e cmd;

  assign cmd = wake_cmd_e'(host_data_i[1:0]);

  wake_addr_match #(.ADDR_W(HADDR_W), .LO_W(LO_W)) u_match (
    .addr_i     (host_addr_i),
    .cfg_addr_i (cfg_port_addr_i),
    .wide_i     (cfg_addr16_i),
    .hit_o      (hit)
  );

  wake_cmd_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (host_iowr_i),
    .hit_i       (hit),
    .cmd_i       (cmd),
    .board_rst_o (board_rst_o),
    .attn_o      (chan_attn_o),
    .clr_irq_o   (clr_irq)
  );

  irq_latch #(
    .NUM_IRQ(NUM_IRQ), .LADDR_W(LADDR_W), .LDATA_W(LDATA_W),
    .IRQ_PORT(IRQ_PORT), .IRQ_BIT(IRQ_BIT)
  ) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .loc_wr_i   (loc_iowr_i),
    .loc_addr_i (loc_addr_i),
    .loc_data_i (loc_data_i),
    .clr_i      (clr_irq),
    .sel_i      (cfg_irq_sel_i),
    .irq_no     (host_irq_no),
    .pending_o  (pending)
  );

  assert_clear_pairs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pending) && !$past(loc_iowr_i)) |-> !board_rst_o);
endmodule

// File: tb/host_wake_port_test.sv
module host_wake_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_addr = 16'hA53C;
  logic        cfg16 = 1'b1;
  logic [7:0]  sel = 8'h04;
  logic        iowr = 1'b0;
  logic [15:0] haddr = '0;
  logic [7:0]  hdata = '0;
  logic        lwr = 1'b0;
  logic [15:0] laddr = '0;
  logic [15:0] ldata = '0;
  logic        brst;
  logic        attn;
  logic [7:0]  irq_n;

  int n_chk = 0;
  int n_err = 0;
  bit m_rst = 1'b1;
  bit m_irq = 1'b0;

  always #2 clk = ~clk;

  host_wake_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_port_addr_i(cfg_addr), .cfg_addr16_i(cfg16),
    .cfg_irq_sel_i(sel), .host_iowr_i(iowr), .host_addr_i(haddr), .host_data_i(hdata),
    .loc_iowr_i(lwr), .loc_addr_i(laddr), .loc_data_i(ldata),
    .board_rst_o(brst), .chan_attn_o(attn), .host_irq_no(irq_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_irq();
    return m_irq ? ~sel : 8'hFF;
  endfunction

  task automatic check_state(input string tag);
    chk(brst == m_rst, {tag, " board_rst"}, 16'(brst), 16'(m_rst));
    chk(irq_n == exp_irq(), {tag, " irq lines"}, 16'(irq_n), 16'(exp_irq()));
  endtask

  task automatic host_wr(input logic [15:0] a, input logic [7:0] d, input bit loc_same, input string tag);
    bit match;
    bit ca;
    @(negedge clk); iowr = 1'b1; haddr = a; hdata = d;
    @(negedge clk);
    @(negedge clk); iowr = 1'b0; haddr = ~a; hdata = ~d;
    if (loc_same) begin lwr = 1'b1; laddr = 16'h8010; ldata = 16'h0100; end
    // trailing edge is the next posedge
    match = (a[7:0] == cfg_addr[7:0]) && (!cfg16 || a[15:8] == cfg_addr[15:8]);
    ca = 1'b0;
    if (match) begin
      case (d[1:0])
        2'b00: begin m_rst = 1'b0; m_irq = 1'b0; end
        2'b01: ca = !m_rst;
        2'b10: m_rst = 1'b1;
        default: ;
      endcase
    end
    if (loc_same) m_irq = 1'b1;
    @(negedge clk); lwr = 1'b0;
    chk(attn == ca, {tag, " attn pulse"}, 16'(attn), 16'(ca));
    check_state(tag);
    @(negedge clk);
    chk(attn == 1'b0, {tag, " attn single cycle R6"}, 16'(attn), 16'h0);
  endtask

  task automatic loc_write(input logic [15:0] a, input logic [15:0] d, input string tag);
    @(negedge clk); lwr = 1'b1; laddr = a; ldata = d;
    @(negedge clk); lwr = 1'b0;
    if (a == 16'h8010 && d[8]) m_irq = 1'b1;
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R9 in reset");
    chk(attn == 1'b0, "R9 attn in reset", 16'(attn), 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_state("R9 after reset");

    // CA while held in reset is ignored
    host_wr(16'hA53C, 8'h01, 1'b0, "R6 attn during reset");

    // full command byte sweep
    for (int d = 0; d < 256; d++) begin
      string t;
      if (d % 3 == 0) loc_write(16'h8010, 16'h0100, "R7 set");
      case (d & 3)
        0: t = "R5 clear";
        1: t = "R6 attn";
        2: t = "R4 reset";
        default: t = "R3 no-op";
      endcase
      host_wr(16'hA53C, 8'(d), 1'b0, t);
    end
    host_wr(16'hA53C, 8'h02, 1'b0, "R4 reset");
    host_wr(16'hA53C, 8'h01, 1'b0, "R6 attn during reset");
    host_wr(16'hA53C, 8'h03, 1'b0, "R4 held through no-op");
    host_wr(16'hA53C, 8'h00, 1'b0, "R5 clear");

    // 16-bit address compare: every single-bit miss
    cfg16 = 1'b1;
    for (int b = 0; b < 16; b++)
      host_wr(16'hA53C ^ 16'(1 << b), 8'h02, 1'b0, "R1 miss");
    host_wr(16'hA53C, 8'h01, 1'b0, "R1 hit attn");

    // 8-bit compare: high byte ignored
    cfg16 = 1'b0;
    for (int b = 0; b < 16; b++) begin
      host_wr(16'hA53C ^ 16'(1 << b), 8'h02, 1'b0, "R2 compare");
      host_wr(16'hA53C, 8'h00, 1'b0, "R2 restore");
    end
    host_wr(16'h003C, 8'h01, 1'b0, "R2 high byte zero");
    cfg16 = 1'b1;

    // local latch
    loc_write(16'h8011, 16'h0100, "R7 wrong port");
    loc_write(16'h8010, 16'h00FF, "R7 bit8 clear");
    loc_write(16'h8010, 16'hFEFF, "R7 bit8 clear high");
    loc_write(16'h8010, 16'h0100, "R7 set");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sel = 8'(1 << i);
      @(negedge clk);
      check_state("R8 line select");
    end
    sel = 8'h00;
    @(negedge clk);
    check_state("R8 no line selected");
    sel = 8'h10;
    host_wr(16'hA53C, 8'h00, 1'b0, "R5 clear irq");
    host_wr(16'hA53C, 8'h00, 1'b1, "R7 set wins over clear");
    host_wr(16'hA53C, 8'h02, 1'b0, "R4 reset keeps irq");
    host_wr(16'hA53C, 8'h00, 1'b0, "R5 clear both");

    // power-on reset again
    loc_write(16'h8010, 16'h0100, "R7 set");
    @(negedge clk); rst_n = 1'b0;
    m_rst = 1'b1; m_irq = 1'b0;
    @(negedge clk);
    check_state("R9 reapplied");
    chk(attn == 1'b0, "R9 attn reapplied", 16'(attn), 16'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule